// File: doc/BRIEF.md
# Two-Arm Intersection Signal Sequencer

This block drives the lamps of a junction where two approaches ("arms") take turns. Each arm is served in four steps: a straight-and-right green, a yellow, a protected left-turn arrow shown with red, and a second yellow. Service then passes to the opposite arm. A walk phase, with both arms held at red, can be placed between the two services. A button press is remembered and served at the next handover. It never cuts into an arm's service.

When to end a green or an arrow is decided outside this block and reaches it as a one-bit switch request. The length of each yellow is measured by an external timer. The block reads that timer's 2-bit value and pulses a restart strobe whenever it changes state. After a synchronous clear, the block starts from an all-red state and uses the arm-select input to pick which arm is served first.

Top module: `isect_seq`

## Requirements
- R1: While `clr` is high, both lamps are red (code 0), `phase` is 0 and `tmr_rst` is 0, and any remembered walk request is discarded. At the first clock edge with `clr` low, the arm named by `arm_sel` (0 selects lamp_a, 1 selects lamp_b) turns green (code 2).
- R2: Lamp codes are red 0, yellow 1, green 2, red-with-left-arrow 3. A served arm moves green, yellow, arrow, yellow, in that order.
- R3: A green or arrow state holds while `sw_req` is 0. On a clock edge with `sw_req` at 1, it moves to the yellow that follows.
- R4: A yellow holds while `tmr` is below 2, whatever `sw_req` is. It advances on an edge where `tmr` is 2 or more.
- R5: When the closing yellow ends and no walk request is pending, the other arm goes green at that edge.
- R6: When the closing yellow ends and a walk request is pending, the block enters the walk phase: both lamps red and `phase` 3. It stays there while `sw_req` is 0. On `sw_req` at 1, the arm that was not just served goes green and the pending request is cleared.
- R7: A one-cycle pulse on `ped_btn` is remembered and does not disturb the service in progress.
- R8: At every cycle, at least one of the two lamps is red.
- R9: `phase` is 1 while lamp_a is being served, 2 while lamp_b is being served, 3 during the walk phase, and 0 in the initial state.
- R10: `tmr_rst` is 1 for exactly the first cycle in which a new state is shown on the outputs, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| sw_req | input | 1 | Request to end the current green, arrow or walk state |
| arm_sel | input | 1 | Arm served first after clear |
| ped_btn | input | 1 | Pedestrian button pulse |
| tmr | input | 2 | External phase timer value |
| lamp_a | output | 2 | Lamp code for arm 0 |
| lamp_b | output | 2 | Lamp code for arm 1 |
| phase | output | 2 | Phase indicator |
| tmr_rst | output | 1 | One-cycle restart strobe for the external timer |

## Verification
The sequence is run starting from each arm:
- A full service with no button press shows that the handover goes straight to the other arm.
- A service with a button pulse in the middle shows that the walk phase is deferred to the handover and is left only on a switch request.
- A later service shows that the request was cleared.

Yellows are held with the timer at 0, 1 and 1 with the switch request high, then released with the timer at 2 and at 3. This separates "equals 2" from "at least 2" and shows that the switch request is ignored during yellow. A button press followed by a clear shows that the clear discards the request.

// File: rtl/isect_pkg.sv
package isect_pkg;

    typedef enum logic [3:0] {
        ST_INIT = 4'd0,
        ST_GRN0 = 4'd1,
        ST_YLA0 = 4'd2,
        ST_ARW0 = 4'd3,
        ST_YLB0 = 4'd4,
        ST_GRN1 = 4'd5,
        ST_YLA1 = 4'd6,
        ST_ARW1 = 4'd7,
        ST_YLB1 = 4'd8,
        ST_WALK = 4'd9
    } st_e;

    typedef enum logic [1:0] {
        LAMP_RED = 2'd0,
        LAMP_YEL = 2'd1,
        LAMP_GRN = 2'd2,
        LAMP_ARW = 2'd3
    } lamp_e;

    localparam logic [1:0] PH_IDLE = 2'd0;
    localparam logic [1:0] PH_ARM0 = 2'd1;
    localparam logic [1:0] PH_ARM1 = 2'd2;
    localparam logic [1:0] PH_WALK = 2'd3;

    // which arm a state serves; meaningful only when st_served is true
    function automatic logic st_arm(st_e s);
        return (s == ST_GRN1) || (s == ST_YLA1) || (s == ST_ARW1) || (s == ST_YLB1);
    endfunction

    function automatic logic st_served(st_e s);
        return (s != ST_INIT) && (s != ST_WALK);
    endfunction

    function automatic lamp_e st_lamp(st_e s);
        case (s)
            ST_GRN0, ST_GRN1: return LAMP_GRN;
            ST_YLA0, ST_YLA1,
            ST_YLB0, ST_YLB1: return LAMP_YEL;
            ST_ARW0, ST_ARW1: return LAMP_ARW;
            default:          return LAMP_RED;
        endcase
    endfunction

    function automatic logic [1:0] st_phase(st_e s);
        if (s == ST_WALK) return PH_WALK;
        if (s == ST_INIT) return PH_IDLE;
        return st_arm(s) ? PH_ARM1 : PH_ARM0;
    endfunction

    function automatic st_e green_of(logic arm);
        return arm ? ST_GRN1 : ST_GRN0;
    endfunction

endpackage

// File: rtl/isect_walk_latch.sv
module isect_walk_latch (
    input  logic clk,
    input  logic clr,
    input  logic ped_btn,
    input  logic walk_done,
    output logic pend_q
);
    logic pend_d;

    always_comb begin
        pend_d = (pend_q & ~walk_done) | ped_btn;
    end

    always_ff @(posedge clk) begin
        if (clr) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    AST_PRESS_LATCHED: assert property (@(posedge clk) disable iff (clr)
        ped_btn |=> pend_q); // R7

endmodule

// File: rtl/isect_step.sv
module isect_step
    import isect_pkg::*;
#(
    parameter int TMR_W     = 2,
    parameter int YEL_TICKS = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             sw_req,
    input  logic             arm_sel,
    input  logic [TMR_W-1:0] tmr,
    input  logic             pend,
    output st_e              st_d,
    output st_e              st_q,
    output logic             walk_done
);
    localparam logic [TMR_W-1:0] YEL_LIM = TMR_W'(YEL_TICKS);

    typedef struct packed {
        st_e  st;
        logic nxt_arm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic yel_over;

    always_comb begin
        ctl_d     = ctl_q;
        yel_over  = (tmr >= YEL_LIM);
        walk_done = 1'b0;
        case (ctl_q.st)
            ST_INIT: ctl_d.st = green_of(arm_sel);
            ST_GRN0: if (sw_req) ctl_d.st = ST_YLA0;
            ST_YLA0: if (yel_over) ctl_d.st = ST_ARW0;
            ST_ARW0: if (sw_req) ctl_d.st = ST_YLB0;
            ST_YLB0: if (yel_over) begin
                ctl_d.nxt_arm = 1'b1;
                ctl_d.st      = pend ? ST_WALK : ST_GRN1;
            end
            ST_GRN1: if (sw_req) ctl_d.st = ST_YLA1;
            ST_YLA1: if (yel_over) ctl_d.st = ST_ARW1;
            ST_ARW1: if (sw_req) ctl_d.st = ST_YLB1;
            ST_YLB1: if (yel_over) begin
                ctl_d.nxt_arm = 1'b0;
                ctl_d.st      = pend ? ST_WALK : ST_GRN0;
            end
            ST_WALK: if (sw_req) begin
                walk_done = 1'b1;
                ctl_d.st  = green_of(ctl_q.nxt_arm);
            end
            default: ctl_d.st = ST_INIT;
        endcase
        if (clr) begin
            ctl_d.st      = ST_INIT;
            ctl_d.nxt_arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign st_d = ctl_d.st;
    assign st_q = ctl_q.st;

    AST_WALK_ENTRY: assert property (@(posedge clk) disable iff (clr)
        (st_q == ST_WALK && $past(st_q) != ST_WALK) |->
        ($past(st_q) == ST_YLB0 || $past(st_q) == ST_YLB1)); // R6

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (clr)
        (st_q == ST_WALK && !sw_req) |=> st_q == ST_WALK); // R6

endmodule

// File: rtl/isect_lamp_drv.sv
module isect_lamp_drv
    import isect_pkg::*;
#(
    parameter logic ARM = 1'b0
) (
    input  logic       clk,
    input  logic       clr,
    input  st_e        st_d,
    output logic [1:0] lamp_q
);
    logic [1:0] lamp_d;

    always_comb begin
        if (st_served(st_d) && (st_arm(st_d) == ARM)) lamp_d = st_lamp(st_d);
        else                                          lamp_d = LAMP_RED;
    end

    always_ff @(posedge clk) begin
        if (clr) lamp_q <= LAMP_RED;
        else     lamp_q <= lamp_d;
    end

endmodule

// File: rtl/isect_seq.sv
module isect_seq
    import isect_pkg::*;
#(
    parameter int TMR_W     = 2,
    parameter int YEL_TICKS = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             sw_req,
    input  logic             arm_sel,
    input  logic             ped_btn,
    input  logic [TMR_W-1:0] tmr,
    output logic [1:0]       lamp_a,
    output logic [1:0]       lamp_b,
    output logic [1:0]       phase,
    output logic             tmr_rst
);
    localparam int N_ARMS = 2;

    typedef struct packed {
        logic [1:0] ph;
        logic       rst;
    } out_t;

    st_e  st_d, st_q;
    logic pend, walk_done;
    logic [1:0] lamp_w [N_ARMS];
    out_t out_d, out_q;

    isect_walk_latch u_walk (
        .clk      (clk),
        .clr      (clr),
        .ped_btn  (ped_btn),
        .walk_done(walk_done),
        .pend_q   (pend)
    );

    isect_step #(.TMR_W(TMR_W), .YEL_TICKS(YEL_TICKS)) u_step (
        .clk      (clk),
        .clr      (clr),
        .sw_req   (sw_req),
        .arm_sel  (arm_sel),
        .tmr      (tmr),
        .pend     (pend),
        .st_d     (st_d),
        .st_q     (st_q),
        .walk_done(walk_done)
    );

    for (genvar g = 0; g < N_ARMS; g++) begin : g_lamp
        isect_lamp_drv #(.ARM(1'(g))) u_drv (
            .clk   (clk),
            .clr   (clr),
            .st_d  (st_d),
            .lamp_q(lamp_w[g])
        );
    end

    always_comb begin
        out_d.ph  = st_phase(st_d);
        out_d.rst = (st_d != st_q);
        if (clr) out_d = '0;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign lamp_a  = lamp_w[0];
    assign lamp_b  = lamp_w[1];
    assign phase   = out_q.ph;
    assign tmr_rst = out_q.rst;

    AST_ONE_ARM_LIT: assert property (@(posedge clk) disable iff (clr)
        (lamp_a == LAMP_RED) || (lamp_b == LAMP_RED)); // R8

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (clr)
        !$stable({lamp_a, lamp_b, phase}) |-> tmr_rst); // R10

    AST_GREEN_HELD: assert property (@(posedge clk) disable iff (clr)
        (lamp_a == LAMP_GRN && !sw_req) |=> lamp_a == LAMP_GRN); // R3

    AST_YELLOW_WAIT: assert property (@(posedge clk) disable iff (clr)
        (lamp_b == LAMP_YEL && tmr < TMR_W'(YEL_TICKS)) |=> lamp_b == LAMP_YEL); // R4

    AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (clr)
        (phase == PH_ARM0) |-> lamp_b == LAMP_RED); // R9

endmodule

// File: tb/tb_isect_seq.sv
`timescale 1ns/1ps
module tb_isect_seq;
    logic       clk = 1'b0;
    logic       clr, sw_req, arm_sel, ped_btn;
    logic [1:0] tmr;
    logic [1:0] lamp_a, lamp_b, phase;
    logic       tmr_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [1:0] RED = 2'd0, YEL = 2'd1, GRN = 2'd2, ARW = 2'd3;

    always #2.5 clk = ~clk;

    isect_seq dut (
        .clk(clk), .clr(clr), .sw_req(sw_req), .arm_sel(arm_sel),
        .ped_btn(ped_btn), .tmr(tmr), .lamp_a(lamp_a), .lamp_b(lamp_b),
        .phase(phase), .tmr_rst(tmr_rst)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [1:0] ea, input logic [1:0] eb,
                              input logic [1:0] ep, input logic er);
        n_chk++;
        if (lamp_a !== ea || lamp_b !== eb || phase !== ep || tmr_rst !== er) begin
            n_fail++;
            $display("FAIL %s: got a=%0d b=%0d ph=%0d rst=%0d, want a=%0d b=%0d ph=%0d rst=%0d",
                     tag, lamp_a, lamp_b, phase, tmr_rst, ea, eb, ep, er);
        end
        n_chk++;
        if (lamp_a !== RED && lamp_b !== RED) begin
            n_fail++;
            $display("FAIL R8 (%s): got a=%0d b=%0d, want one red", tag, lamp_a, lamp_b);
        end
    endtask

    task automatic do_clear(input logic arm);
        clr = 1'b1; sw_req = 1'b0; tmr = 2'd0; ped_btn = 1'b0; arm_sel = arm;
        step(2);
        expect_out("R1 clear state", RED, RED, 2'd0, 1'b0);
        clr = 1'b0;
        step(1);
        if (arm) expect_out("R1 first arm 1", RED, GRN, 2'd2, 1'b1);
        else     expect_out("R1 first arm 0", GRN, RED, 2'd1, 1'b1);
    endtask

    // one arm's service, no walk pending at the end
    task automatic t_plain_service;
        do_clear(1'b0);
        step(3);
        expect_out("R3 green held", GRN, RED, 2'd1, 1'b0);
        sw_req = 1'b1; step(1);
        expect_out("R2 green to yellow", YEL, RED, 2'd1, 1'b1);
        tmr = 2'd0; step(1);
        expect_out("R4 yellow with tmr 0 and sw 1", YEL, RED, 2'd1, 1'b0);
        sw_req = 1'b0; tmr = 2'd1; step(2);
        expect_out("R4 yellow with tmr 1", YEL, RED, 2'd1, 1'b0);
        tmr = 2'd2; step(1);
        expect_out("R2 R4 yellow to arrow", ARW, RED, 2'd1, 1'b1);
        tmr = 2'd0; step(2);
        expect_out("R3 arrow held", ARW, RED, 2'd1, 1'b0);
        sw_req = 1'b1; step(1);
        expect_out("R2 arrow to yellow", YEL, RED, 2'd1, 1'b1);
        sw_req = 1'b0; tmr = 2'd2; step(1);
        expect_out("R5 R9 handover to arm 1", RED, GRN, 2'd2, 1'b1);
        tmr = 2'd0; step(1);
        expect_out("R10 strobe drops", RED, GRN, 2'd2, 1'b0);
    endtask

    // arm 1 first, button pressed mid-green, walk at handover
    task automatic t_walk;
        do_clear(1'b1);
        ped_btn = 1'b1; step(1); ped_btn = 1'b0;
        expect_out("R7 press does not interrupt", RED, GRN, 2'd2, 1'b0);
        sw_req = 1'b1; step(1);
        expect_out("R2 arm1 yellow", RED, YEL, 2'd2, 1'b1);
        sw_req = 1'b0; tmr = 2'd3; step(1);
        expect_out("R4 tmr 3 releases yellow", RED, ARW, 2'd2, 1'b1);
        tmr = 2'd0; sw_req = 1'b1; step(1);
        expect_out("R2 arm1 closing yellow", RED, YEL, 2'd2, 1'b1);
        sw_req = 1'b0; tmr = 2'd2; step(1);
        expect_out("R6 walk entered", RED, RED, 2'd3, 1'b1);
        tmr = 2'd0; step(3);
        expect_out("R6 walk held", RED, RED, 2'd3, 1'b0);
        sw_req = 1'b1; step(1);
        expect_out("R6 walk exits to arm 0", GRN, RED, 2'd1, 1'b1);
        step(1);
        expect_out("R2 arm0 yellow after walk", YEL, RED, 2'd1, 1'b1);
        sw_req = 1'b0; tmr = 2'd2; step(1);
        expect_out("R2 arm0 arrow", ARW, RED, 2'd1, 1'b1);
        tmr = 2'd0; sw_req = 1'b1; step(1);
        expect_out("R2 arm0 closing yellow", YEL, RED, 2'd1, 1'b1);
        sw_req = 1'b0; tmr = 2'd2; step(1);
        expect_out("R6 request cleared, no second walk", RED, GRN, 2'd2, 1'b1);
        tmr = 2'd0;
    endtask

    // a press before clear is discarded
    task automatic t_clear_drops_press;
        ped_btn = 1'b1; step(1); ped_btn = 1'b0;
        do_clear(1'b0);
        sw_req = 1'b1; step(1);
        sw_req = 1'b0; tmr = 2'd2; step(1);
        tmr = 2'd0; sw_req = 1'b1; step(1);
        expect_out("R2 closing yellow", YEL, RED, 2'd1, 1'b1);
        sw_req = 1'b0; tmr = 2'd2; step(1);
        expect_out("R1 press discarded by clear", RED, GRN, 2'd2, 1'b1);
        tmr = 2'd0;
    endtask

    initial begin
        clr = 1'b1; sw_req = 1'b0; arm_sel = 1'b0; ped_btn = 1'b0; tmr = 2'd0;
        t_plain_service();
        t_walk();
        t_clear_drops_press();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule